// File: doc/BRIEF.md
# Dual-Sample ADC Phase Sequencer and Computation Status

This block steps an external analog-to-digital converter through three phases for each sample: precharge, acquisition and conversion. A sample completes one phase when the converter raises a done strobe for that phase. The block can take a second sample after the first. When the second sample is started by a separate trigger, the sequencer waits between the two samples in a suspended state. In that state the computation results stay incomplete until the second sample arrives. The current phase is published as a 3-bit code, and one enable line is held high for each phase type.

The same block keeps the status flags of the computation unit that follows the converter:
- a sticky overflow flag, fed by overflow pulses from the accumulator, filter and error paths;
- two threshold flags, which compare a signed error value against an upper and a lower limit;
- a computation-updated flag that software can clear.

Software cannot clear the computation-updated flag while the sequencer is suspended between samples. All of the status is packed into one byte.

Top module: `adc_seq_status`

## Requirements
- R1: After reset the status byte is 0x00 and no phase enable is high.
- R2: The status byte is laid out as bit 7 overflow, bit 6 upper flag, bit 5 lower flag, bit 4 computation flag, bit 3 always 0, and bits 2:0 the phase code. The phase codes are 000 idle; 001, 010 and 011 first precharge, acquisition and conversion; 101, 110 and 111 second precharge, acquisition and conversion. A trigger in idle moves the phase to 001 on the next cycle. A done strobe in precharge or acquisition moves the phase to the next code on the next cycle.
- R3: A done strobe in 011 moves the phase as follows: to 100 when double-sample is on and continuous is off; to 101 when both are on; to 001 when double-sample is off and continuous is on; to 000 when both are off.
- R4: In code 100 a trigger moves the phase to 101. A done strobe in code 100 has no effect.
- R5: A trigger in any state other than 000 or 100 is ignored. Without a done strobe, the phase does not change.
- R6: A done strobe in 111 moves the phase to 001 when continuous is on, and to 000 otherwise.
- R7: On each update cycle the upper flag becomes 1 when the error is greater than the upper limit, and 0 otherwise. The compare is two's complement. An update cycle is a results-update pulse or any overflow pulse. On all other cycles the upper flag holds its value.
- R8: On each update cycle the lower flag becomes 1 when the error is less than the lower limit, and 0 otherwise. The compare is two's complement. On all other cycles the lower flag holds its value.
- R9: An overflow pulse on any of the three inputs sets the overflow flag, and the flag stays set. It is cleared by a software clear, or by hardware when a trigger starts a sequence from idle. A set in the same cycle as a clear wins.
- R10: A results-update pulse or any overflow pulse sets the computation flag, and the flag holds until it is cleared. A software clear clears it, except in phase 100, where the clear is ignored. A set in the same cycle as a clear wins.
- R11: The precharge enable is high in 001 and 101. The acquisition enable is high in 010 and 110. The conversion enable is high in 011 and 111. At most one enable is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Conversion trigger |
| dbl_en_i | input | 1 | Double-sample enable |
| cont_en_i | input | 1 | Continuous mode enable |
| done_i | input | 1 | Current phase finished |
| err_i | input | ERR_W | Signed error value |
| uth_i | input | ERR_W | Upper limit |
| lth_i | input | ERR_W | Lower limit |
| upd_i | input | 1 | Computation results updated |
| ovf_acc_i | input | 1 | Accumulator overflow pulse |
| ovf_flt_i | input | 1 | Filter overflow pulse |
| ovf_err_i | input | 1 | Error path overflow pulse |
| clr_ovf_i | input | 1 | Software clear of the overflow flag |
| clr_calc_i | input | 1 | Software clear of the computation flag |
| status_o | output | 8 | Packed status byte |
| pre_en_o | output | 1 | Precharge phase enable |
| acq_en_o | output | 1 | Acquisition phase enable |
| conv_en_o | output | 1 | Conversion phase enable |

## Verification
The hardest situation to reach is the suspended state, code 100, while the computation flag is set and a software clear arrives. Reaching it needs double-sample on, continuous off, a trigger, and three done strobes in order. The bench drives exactly that sequence, then raises an update pulse and a clear, and checks that the flag survives. It then moves on to 101 and checks that the same clear now takes effect. A long pseudo-random run over the triggers, done strobes and both mode bits passes through every phase transition, each one compared against an arithmetic next-phase model.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic [2:0] {
      PH_IDLE = 3'b000,
      PH_PRE1 = 3'b001,
      PH_ACQ1 = 3'b010,
      PH_CNV1 = 3'b011,
      PH_HOLD = 3'b100,
      PH_PRE2 = 3'b101,
      PH_ACQ2 = 3'b110,
      PH_CNV2 = 3'b111
   } phase_e;

   localparam int STATUS_W  = 8;
   localparam int BIT_OVF   = 7;
   localparam int BIT_UPPER = 6;
   localparam int BIT_LOWER = 5;
   localparam int BIT_CALC  = 4;
endpackage

// File: rtl/adc_seq_phase.sv
module adc_seq_phase
   import adc_seq_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   trig_i,
   input  logic   done_i,
   input  logic   dbl_i,
   input  logic   cont_i,
   output phase_e phase_o,
   output logic   start_o,
   output logic   pre_o,
   output logic   acq_o,
   output logic   conv_o
);
   phase_e phase_q, phase_d;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE: if (trig_i) phase_d = PH_PRE1;
         PH_PRE1: if (done_i) phase_d = PH_ACQ1;
         PH_ACQ1: if (done_i) phase_d = PH_CNV1;
         PH_CNV1: if (done_i) begin
            if (dbl_i)       phase_d = cont_i ? PH_PRE2 : PH_HOLD;
            else             phase_d = cont_i ? PH_PRE1 : PH_IDLE;
         end
         PH_HOLD: if (trig_i) phase_d = PH_PRE2;
         PH_PRE2: if (done_i) phase_d = PH_ACQ2;
         PH_ACQ2: if (done_i) phase_d = PH_CNV2;
         PH_CNV2: if (done_i) phase_d = cont_i ? PH_PRE1 : PH_IDLE;
         default:             phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) phase_q <= PH_IDLE;
      else        phase_q <= phase_d;
   end

   assign phase_o = phase_q;
   assign start_o = (phase_q == PH_IDLE) && trig_i;
   // low two code bits select the phase type; 00 covers idle and the hold
   assign pre_o   = (phase_q[1:0] == 2'b01);
   assign acq_o   = (phase_q[1:0] == 2'b10);
   assign conv_o  = (phase_q[1:0] == 2'b11);

   p_idle_trig_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_IDLE && trig_i) |=> (phase_q == PH_PRE1));
   p_hold_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_CNV1 && done_i && dbl_i && !cont_i) |=> (phase_q == PH_HOLD));
   p_hold_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_HOLD && trig_i) |=> (phase_q == PH_PRE2));
   p_trig_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_IDLE && phase_q != PH_HOLD && !done_i) |=> $stable(phase_q));
   p_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_CNV2 && done_i && !cont_i) |=> (phase_q == PH_IDLE));
   p_one_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pre_o, acq_o, conv_o}));
endmodule

// File: rtl/adc_seq_flags.sv
module adc_seq_flags #(
   parameter int ERR_W      = 16,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ERR_W-1:0] err_i,
   input  logic [ERR_W-1:0] uth_i,
   input  logic [ERR_W-1:0] lth_i,
   input  logic             upd_i,
   input  logic             ovf_acc_i,
   input  logic             ovf_flt_i,
   input  logic             ovf_err_i,
   input  logic             clr_ovf_i,
   input  logic             hw_clr_ovf_i,
   input  logic             clr_calc_i,
   input  logic             hold_i,
   output logic             ovf_o,
   output logic             upper_o,
   output logic             lower_o,
   output logic             calc_o
);
   if (ERR_W < 2) begin : g_bad_width
      $error("adc_seq_flags: ERR_W must be at least 2");
   end

   logic gt, lt, ovf_any, upd_any;
   logic ovf_q, upper_q, lower_q, calc_q;

   if (SIGNED_CMP) begin : g_signed
      assign gt = $signed(err_i) > $signed(uth_i);
      assign lt = $signed(err_i) < $signed(lth_i);
   end else begin : g_unsigned
      assign gt = err_i > uth_i;
      assign lt = err_i < lth_i;
   end

   assign ovf_any = ovf_acc_i | ovf_flt_i | ovf_err_i;
   assign upd_any = upd_i | ovf_any;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovf_q   <= 1'b0;
         upper_q <= 1'b0;
         lower_q <= 1'b0;
         calc_q  <= 1'b0;
      end else begin
         if (ovf_any)                          ovf_q <= 1'b1;
         else if (clr_ovf_i || hw_clr_ovf_i)   ovf_q <= 1'b0;
         if (upd_any) begin
            upper_q <= gt;
            lower_q <= lt;
         end
         if (upd_any)                          calc_q <= 1'b1;
         else if (clr_calc_i && !hold_i)       calc_q <= 1'b0;
      end
   end

   assign ovf_o   = ovf_q;
   assign upper_o = upper_q;
   assign lower_o = lower_q;
   assign calc_o  = calc_q;

   p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !clr_ovf_i && !hw_clr_ovf_i) |=> ovf_q);
   p_thr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_any |=> $stable({upper_q, lower_q}));
   p_calc_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_i && calc_q) |=> calc_q);
endmodule

// File: rtl/adc_seq_status.sv
module adc_seq_status
   import adc_seq_pkg::*;
#(
   parameter int ERR_W      = 16,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                trig_i,
   input  logic                dbl_en_i,
   input  logic                cont_en_i,
   input  logic                done_i,
   input  logic [ERR_W-1:0]    err_i,
   input  logic [ERR_W-1:0]    uth_i,
   input  logic [ERR_W-1:0]    lth_i,
   input  logic                upd_i,
   input  logic                ovf_acc_i,
   input  logic                ovf_flt_i,
   input  logic                ovf_err_i,
   input  logic                clr_ovf_i,
   input  logic                clr_calc_i,
   output logic [STATUS_W-1:0] status_o,
   output logic                pre_en_o,
   output logic                acq_en_o,
   output logic                conv_en_o
);
   phase_e phase;
   logic   start, ovf, upper, lower, calc;

   adc_seq_phase u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig_i  (trig_i),
      .done_i  (done_i),
      .dbl_i   (dbl_en_i),
      .cont_i  (cont_en_i),
      .phase_o (phase),
      .start_o (start),
      .pre_o   (pre_en_o),
      .acq_o   (acq_en_o),
      .conv_o  (conv_en_o)
   );

   adc_seq_flags #(.ERR_W(ERR_W), .SIGNED_CMP(SIGNED_CMP)) u_flags (
      .clk          (clk),
      .rst_n        (rst_n),
      .err_i        (err_i),
      .uth_i        (uth_i),
      .lth_i        (lth_i),
      .upd_i        (upd_i),
      .ovf_acc_i    (ovf_acc_i),
      .ovf_flt_i    (ovf_flt_i),
      .ovf_err_i    (ovf_err_i),
      .clr_ovf_i    (clr_ovf_i),
      .hw_clr_ovf_i (start),
      .clr_calc_i   (clr_calc_i),
      .hold_i       (phase == PH_HOLD),
      .ovf_o        (ovf),
      .upper_o      (upper),
      .lower_o      (lower),
      .calc_o       (calc)
   );

   always_comb begin
      status_o            = '0;
      status_o[2:0]       = phase;
      status_o[BIT_OVF]   = ovf;
      status_o[BIT_UPPER] = upper;
      status_o[BIT_LOWER] = lower;
      status_o[BIT_CALC]  = calc;
   end

   p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[3] == 1'b0);
endmodule

// File: tb/adc_seq_status_tb_top.sv
module adc_seq_status_tb_top;
   localparam int EW = 4;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, trig, dbl, cont, done, upd, oa, of, oe, cov, ccl;
   logic [EW-1:0] err, uth, lth;
   logic [7:0] st;
   logic pre, acq, conv;

   int total = 0, bad = 0;

   adc_seq_status #(.ERR_W(EW), .SIGNED_CMP(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .trig_i(trig), .dbl_en_i(dbl), .cont_en_i(cont),
      .done_i(done), .err_i(err), .uth_i(uth), .lth_i(lth), .upd_i(upd),
      .ovf_acc_i(oa), .ovf_flt_i(of), .ovf_err_i(oe), .clr_ovf_i(cov),
      .clr_calc_i(ccl), .status_o(st), .pre_en_o(pre), .acq_en_o(acq), .conv_en_o(conv)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   function automatic int sx(input int v);
      return (v >= (1 << (EW - 1))) ? v - (1 << EW) : v;
   endfunction

   function automatic int nxt(input int ph, input bit t, input bit d, input bit db, input bit ct);
      case (ph)
         0:       return t ? 1 : 0;
         1, 2:    return d ? ph + 1 : ph;
         3:       return d ? (db ? (ct ? 5 : 4) : (ct ? 1 : 0)) : 3;
         4:       return t ? 5 : 4;
         5, 6:    return d ? ph + 1 : ph;
         default: return d ? (ct ? 1 : 0) : 7;
      endcase
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      step();
      step();
      rst_n = 1'b1;
   endtask

   initial begin
      #(20 * 150000);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] lf;
      int ph;
      {trig, dbl, cont, done, upd, oa, of, oe, cov, ccl} = '0;
      err = '0; uth = '0; lth = '0;
      do_reset();
      // R1: reset state
      chk(st == 8'h00, "R1 status", st, 0);
      chk({pre, acq, conv} == 3'b000, "R1 enables", {pre, acq, conv}, 0);

      // pseudo-random phase walk against the next-phase model
      lf = 16'hACE1;
      ph = 0;
      for (int i = 0; i < 3000; i++) begin
         string tag;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         trig = (lf[1:0] == 2'b00);
         done = lf[3];
         dbl  = lf[5];
         cont = lf[7] & lf[8];
         if (ph == 0)      tag = "R2";
         else if (ph == 3) tag = "R3";
         else if (ph == 4) tag = "R4";
         else if (ph == 7) tag = "R6";
         else if (trig && !done) tag = "R5";
         else              tag = "R2";
         ph = nxt(ph, trig, done, dbl, cont);
         step();
         chk(int'(st[2:0]) == ph, tag, st[2:0], ph);
         chk(st[3] == 1'b0, "R2 bit3", st[3], 0);
         chk(pre == (ph == 1 || ph == 5) && acq == (ph == 2 || ph == 6) &&
             conv == (ph == 3 || ph == 7), "R11", {pre, acq, conv}, ph);
      end
      {trig, dbl, cont, done} = '0;

      // computation-flag lock in the suspended state
      do_reset();
      dbl = 1'b1;
      trig = 1'b1; step(); trig = 1'b0;
      done = 1'b1; step(); step(); step(); done = 1'b0;
      chk(st[2:0] == 3'b100, "R3 reach hold", st[2:0], 4);
      upd = 1'b1; step(); upd = 1'b0;
      chk(st[4] == 1'b1, "R10 set", st[4], 1);
      step(); step();
      chk(st[4] == 1'b1, "R10 held", st[4], 1);
      ccl = 1'b1; step(); ccl = 1'b0;
      chk(st[4] == 1'b1, "R10 clear locked in hold", st[4], 1);
      done = 1'b1; step(); done = 1'b0;
      chk(st[2:0] == 3'b100, "R4 done ignored in hold", st[2:0], 4);
      trig = 1'b1; step(); trig = 1'b0;
      chk(st[2:0] == 3'b101, "R4 trig leaves hold", st[2:0], 5);
      ccl = 1'b1; step(); ccl = 1'b0;
      chk(st[4] == 1'b0, "R10 clear outside hold", st[4], 0);
      upd = 1'b1; ccl = 1'b1; step(); upd = 1'b0; ccl = 1'b0;
      chk(st[4] == 1'b1, "R10 set wins", st[4], 1);
      dbl = 1'b0;

      // overflow flag
      for (int k = 0; k < 3; k++) begin
         do_reset();
         oa = (k == 0); of = (k == 1); oe = (k == 2);
         step();
         {oa, of, oe} = '0;
         chk(st[7] == 1'b1, "R9 set", k, 1);
         chk(st[4] == 1'b1, "R10 set by overflow", st[4], 1);
         step(); step();
         chk(st[7] == 1'b1, "R9 sticky", st[7], 1);
         cov = 1'b1; step(); cov = 1'b0;
         chk(st[7] == 1'b0, "R9 sw clear", st[7], 0);
      end
      oe = 1'b1; cov = 1'b1; step(); oe = 1'b0; cov = 1'b0;
      chk(st[7] == 1'b1, "R9 set wins", st[7], 1);
      trig = 1'b1; step(); trig = 1'b0;
      chk(st[7] == 1'b0, "R9 hw clear on start", st[7], 0);
      chk(st[2:0] == 3'b001, "R2 start", st[2:0], 1);

      // exhaustive threshold sweep
      do_reset();
      for (int e = 0; e < (1 << EW); e++)
         for (int u = 0; u < (1 << EW); u++)
            for (int l = 0; l < (1 << EW); l++) begin
               bit eu, el;
               eu = sx(e) > sx(u);
               el = sx(e) < sx(l);
               err = e[EW-1:0]; uth = u[EW-1:0]; lth = l[EW-1:0];
               upd = 1'b1; step(); upd = 1'b0;
               chk(st[6] == eu, "R7 upper", st[6], eu);
               chk(st[5] == el, "R8 lower", st[5], el);
               err = ~err; uth = lth; lth = ~lth;
               step();
               chk(st[6] == eu, "R7 hold", st[6], eu);
               chk(st[5] == el, "R8 hold", st[5], el);
            end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule